// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block sits beside a timer counter and decides, on every clock cycle, whether that counter should advance, in which direction, and whether it should be reinitialised or started. One trigger source is picked from seven candidates: four internal triggers from neighbouring timers, two timer inputs and an external trigger. The picked trigger is then interpreted according to a mode field. The mode field can make the block act as a quadrature encoder interface, a synchronous reset source, a gate, a start trigger, an external clock, or a combined reset and start.

Every input passes through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the one before it. All outputs are registered, so the counter sees a single-cycle strobe one cycle after the synchronized edge. The counter, its prescaler and its enable register are outside the block. The state of that enable register comes in on `counter_en`. A start request goes back out on `cen_set`.

Top module: `slave_mode_ctrl`

## Requirements
- R1: Under reset (`rst_n` low at a clock edge) all five outputs are 0 after that edge.
- R2: With `mode_sel` 0000, or any undefined code from 1001 to 1111, `cnt_en` follows `counter_en` with one cycle of delay. In these modes `cnt_dir`, `cnt_rst`, `upd_req` and `cen_set` stay 0 whatever the trigger inputs do.
- R3: A rising edge on the selected trigger input shows up at the outputs after the third rising clock edge that follows the input change, and lasts exactly one cycle.
- R4: `trig_sel` picks the source. Codes 000 to 011 pick internal triggers 0 to 3. Code 100 picks either edge of channel 1. Code 101 picks channel 1, 110 picks channel 2 and 111 picks the external trigger. Activity on inputs that are not selected has no effect.
- R5: Mode 0100 (reset): each trigger rising edge produces one cycle of `cnt_rst` together with `upd_req`. Meanwhile `cnt_en` follows `counter_en`.
- R6: Mode 0101 (gated): `cnt_en` is high for exactly as many cycles as the synchronized trigger is high, and only while `counter_en` is set. No reset is produced.
- R7: Mode 0110 (start): each trigger rising edge produces one cycle of `cen_set` and no reset. This happens even while `counter_en` is 0.
- R8: Mode 0111 (external clock): `cnt_en` pulses for one cycle per trigger rising edge, and only while `counter_en` is set.
- R9: Mode 1000 (reset and start): each trigger rising edge produces one cycle in which `cnt_rst`, `upd_req` and `cen_set` are all high.
- R10: In the encoder modes, mode 0001 counts edges of channel 2 only, mode 0010 counts edges of channel 1 only, and mode 0011 counts edges of both channels. Each counted edge gives one `cnt_en` pulse.
- R11: In the encoder modes, forward rotation gives `cnt_dir` 0 (up) and reverse rotation gives `cnt_dir` 1 (down). Forward means channel 1 leads channel 2, i.e. the sequence 00, 10, 11, 01 written as (ch1, ch2). `cnt_dir` keeps its value between counted edges. Outside the encoder modes `cnt_dir` is 0.
- R12: In the encoder modes, an edge on one channel is ignored when the other channel changes in the same synchronized cycle. This gives no count and no change of `cnt_dir`.
- R13: With `counter_en` low, `cnt_en` stays 0 in every mode. Reset and start strobes are still issued, and encoder direction is still tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| counter_en | input | 1 | State of the counter's enable register |
| mode_sel | input | 4 | Controller mode |
| trig_sel | input | 3 | Trigger source select |
| int_trig | input | 4 | Internal triggers from other timers |
| ch1_in | input | 1 | Timer channel 1 input (asynchronous) |
| ch2_in | input | 1 | Timer channel 2 input (asynchronous) |
| ext_trig | input | 1 | External trigger input (asynchronous) |
| cnt_en | output | 1 | Counter advance strobe for this cycle |
| cnt_dir | output | 1 | Count direction, 1 = down |
| cnt_rst | output | 1 | Counter reinitialise strobe |
| upd_req | output | 1 | Register update request strobe |
| cen_set | output | 1 | Request to set the counter enable |

## Verification
The assertions check every cycle that strobes come only from the modes allowed to produce them. They also check that `cnt_en` never rises without the enable, that the direction is nonzero only in encoder modes, and that the disabled and undefined modes pass the enable straight through. Edge counts, gate widths, quadrature decoding, rejection of simultaneous channel changes, source selection and the exact three-edge latency depend on input sequences. Those can only be shown by the bench's scenarios, which count output pulses over fixed windows.

// File: rtl/tsm_pkg.sv
// Shared constants for the slave mode controller.
// Assumes exactly four internal triggers, addressed by a 3-bit source select.
package tsm_pkg;

    localparam int NUM_ITRIG = 4;
    localparam int IDX_CH1   = NUM_ITRIG;
    localparam int IDX_CH2   = NUM_ITRIG + 1;
    localparam int IDX_EXT   = NUM_ITRIG + 2;
    localparam int SYNC_W    = NUM_ITRIG + 3;

    typedef enum logic [3:0] {
        SM_OFF       = 4'b0000,
        SM_ENC_CH2   = 4'b0001,
        SM_ENC_CH1   = 4'b0010,
        SM_ENC_BOTH  = 4'b0011,
        SM_RESET     = 4'b0100,
        SM_GATE      = 4'b0101,
        SM_START     = 4'b0110,
        SM_EXTCLK    = 4'b0111,
        SM_RST_START = 4'b1000
    } sm_mode_e;

    typedef enum logic [2:0] {
        TS_ITRIG0   = 3'b000,
        TS_ITRIG1   = 3'b001,
        TS_ITRIG2   = 3'b010,
        TS_ITRIG3   = 3'b011,
        TS_CH1_EDGE = 3'b100,
        TS_CH1      = 3'b101,
        TS_CH2      = 3'b110,
        TS_EXT      = 3'b111
    } ts_src_e;

endpackage

// File: rtl/tsm_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Also keeps the previous synchronized sample so that edges can be found.
// Assumes the inputs are quasi-static relative to the clock (one bit per wire).
module tsm_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);

    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-registers the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    // Hold the last synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= chain[STAGES-1];
    end

    assign cur = chain[STAGES-1];

endmodule

// File: rtl/tsm_trig_sel.sv
// Trigger source multiplexer.
// Gives the level and the rising-edge event of the selected source.
// For the channel-1 edge source, any transition counts as both level and event.
// Assumes cur/prev come from tsm_sync, laid out as in tsm_pkg.
module tsm_trig_sel
    import tsm_pkg::*;
(
    input  logic [SYNC_W-1:0] cur,
    input  logic [SYNC_W-1:0] prev,
    input  logic [2:0]        sel,
    output logic              trig_lvl,
    output logic              trig_rise
);

    logic [SYNC_W-1:0] rise_vec;
    logic              ch1_any;

    assign rise_vec = cur & ~prev;
    assign ch1_any  = cur[IDX_CH1] ^ prev[IDX_CH1];

    // Pick the level and event of the addressed source.
    always_comb begin
        trig_lvl  = 1'b0;
        trig_rise = 1'b0;
        unique case (ts_src_e'(sel))
            TS_ITRIG0, TS_ITRIG1, TS_ITRIG2, TS_ITRIG3: begin
                trig_lvl  = cur[sel[1:0]];
                trig_rise = rise_vec[sel[1:0]];
            end
            TS_CH1_EDGE: begin
                trig_lvl  = ch1_any;
                trig_rise = ch1_any;
            end
            TS_CH1: begin
                trig_lvl  = cur[IDX_CH1];
                trig_rise = rise_vec[IDX_CH1];
            end
            TS_CH2: begin
                trig_lvl  = cur[IDX_CH2];
                trig_rise = rise_vec[IDX_CH2];
            end
            TS_EXT: begin
                trig_lvl  = cur[IDX_EXT];
                trig_rise = rise_vec[IDX_EXT];
            end
            default: begin
                trig_lvl  = 1'b0;
                trig_rise = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tsm_quad.sv
// Quadrature decoder for the two channel inputs.
// Gives a count step and the step's direction (1 = down).
// Forward rotation is channel 1 leading channel 2.
// An edge is dropped when the partner channel changes in the same cycle.
// Assumes synchronized current and previous samples of both channels.
module tsm_quad
    import tsm_pkg::*;
(
    input  logic       a_cur,
    input  logic       a_prev,
    input  logic       b_cur,
    input  logic       b_prev,
    input  logic [3:0] mode,
    output logic       step,
    output logic       step_down
);

    logic a_chg, b_chg, a_ok, b_ok, use_a, use_b;

    assign a_chg = a_cur ^ a_prev;
    assign b_chg = b_cur ^ b_prev;
    assign a_ok  = a_chg & ~b_chg;
    assign b_ok  = b_chg & ~a_chg;
    assign use_a = (mode == SM_ENC_CH1) || (mode == SM_ENC_BOTH);
    assign use_b = (mode == SM_ENC_CH2) || (mode == SM_ENC_BOTH);

    // Qualify the edge against the mode, then derive its direction.
    always_comb begin
        step      = 1'b0;
        step_down = 1'b0;
        if (use_a && a_ok) begin
            step      = 1'b1;
            step_down = (a_cur == b_cur);
        end else if (use_b && b_ok) begin
            step      = 1'b1;
            step_down = (b_cur != a_cur);
        end
    end

endmodule

// File: rtl/tsm_ctrl.sv
// Mode decoder and output registers.
// Turns the trigger and encoder events into registered per-cycle strobes.
// Undefined mode codes behave as the disabled mode.
module tsm_ctrl
    import tsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode,
    input  logic       cen,
    input  logic       trig_lvl,
    input  logic       trig_rise,
    input  logic       step,
    input  logic       step_down,
    output logic       cnt_en,
    output logic       cnt_dir,
    output logic       cnt_rst,
    output logic       upd_req,
    output logic       cen_set
);

    logic en_d, dir_d, rst_d, set_d;

    // Work out this cycle's strobes from the mode.
    always_comb begin
        en_d  = cen;
        dir_d = 1'b0;
        rst_d = 1'b0;
        set_d = 1'b0;
        case (mode)
            SM_ENC_CH2, SM_ENC_CH1, SM_ENC_BOTH: begin
                en_d  = cen & step;
                dir_d = step ? step_down : cnt_dir;
            end
            SM_RESET:     rst_d = trig_rise;
            SM_GATE:      en_d  = cen & trig_lvl;
            SM_START:     set_d = trig_rise;
            SM_EXTCLK:    en_d  = cen & trig_rise;
            SM_RST_START: begin
                rst_d = trig_rise;
                set_d = trig_rise;
            end
            default:      en_d  = cen;
        endcase
    end

    // Register the strobes toward the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en  <= 1'b0;
            cnt_dir <= 1'b0;
            cnt_rst <= 1'b0;
            upd_req <= 1'b0;
            cen_set <= 1'b0;
        end else begin
            cnt_en  <= en_d;
            cnt_dir <= dir_d;
            cnt_rst <= rst_d;
            upd_req <= rst_d;
            cen_set <= set_d;
        end
    end

endmodule

// File: rtl/slave_mode_ctrl.sv
// Top of the timer slave mode controller.
// Synchronizes all trigger inputs, selects one trigger, decodes the
// quadrature channels and issues counter strobes according to mode_sel.
// Assumes the counter itself applies the strobes on the next clock edge.
module slave_mode_ctrl
    import tsm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 counter_en,
    input  logic [3:0]           mode_sel,
    input  logic [2:0]           trig_sel,
    input  logic [NUM_ITRIG-1:0] int_trig,
    input  logic                 ch1_in,
    input  logic                 ch2_in,
    input  logic                 ext_trig,
    output logic                 cnt_en,
    output logic                 cnt_dir,
    output logic                 cnt_rst,
    output logic                 upd_req,
    output logic                 cen_set
);

    logic [SYNC_W-1:0] raw, s_cur, s_prev;
    logic              trig_lvl, trig_rise, step, step_down;

    assign raw = {ext_trig, ch2_in, ch1_in, int_trig};

    tsm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw),
        .cur   (s_cur),
        .prev  (s_prev)
    );

    tsm_trig_sel sel_i (
        .cur       (s_cur),
        .prev      (s_prev),
        .sel       (trig_sel),
        .trig_lvl  (trig_lvl),
        .trig_rise (trig_rise)
    );

    tsm_quad quad_i (
        .a_cur     (s_cur[IDX_CH1]),
        .a_prev    (s_prev[IDX_CH1]),
        .b_cur     (s_cur[IDX_CH2]),
        .b_prev    (s_prev[IDX_CH2]),
        .mode      (mode_sel),
        .step      (step),
        .step_down (step_down)
    );

    tsm_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_sel),
        .cen       (counter_en),
        .trig_lvl  (trig_lvl),
        .trig_rise (trig_rise),
        .step      (step),
        .step_down (step_down),
        .cnt_en    (cnt_en),
        .cnt_dir   (cnt_dir),
        .cnt_rst   (cnt_rst),
        .upd_req   (upd_req),
        .cen_set   (cen_set)
    );

endmodule

// File: rtl/tsm_checker.sv
// Cycle-level properties of the slave mode controller, bound to its top.
// Assumes the outputs are registered from the inputs sampled one edge earlier.
module tsm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       counter_en,
    input logic [3:0] mode_sel,
    input logic       cnt_en,
    input logic       cnt_dir,
    input logic       cnt_rst,
    input logic       cen_set
);

    logic armed;

    // Mark the cycles whose previous sample lies after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_off_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(mode_sel) == 4'd0 || $past(mode_sel) > 4'd8)) |->
        (cnt_en == $past(counter_en) && !cnt_rst && !cen_set && !cnt_dir));

    p_rst_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cnt_rst) |-> ($past(mode_sel) == 4'd4 || $past(mode_sel) == 4'd8));

    p_set_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cen_set) |-> ($past(mode_sel) == 4'd6 || $past(mode_sel) == 4'd8));

    p_dir_enc_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cnt_dir) |-> ($past(mode_sel) >= 4'd1 && $past(mode_sel) <= 4'd3));

    p_en_needs_cen_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cnt_en) |-> $past(counter_en));

endmodule

bind slave_mode_ctrl tsm_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .counter_en (counter_en),
    .mode_sel   (mode_sel),
    .cnt_en     (cnt_en),
    .cnt_dir    (cnt_dir),
    .cnt_rst    (cnt_rst),
    .cen_set    (cen_set)
);

// File: tb/slave_mode_ctrl_tb_top.sv
module slave_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       counter_en = 1'b0;
    logic [3:0] mode_sel = 4'd0;
    logic [2:0] trig_sel = 3'd0;
    logic [3:0] int_trig = 4'd0;
    logic       ch1_in = 1'b0, ch2_in = 1'b0, ext_trig = 1'b0;
    logic       cnt_en, cnt_dir, cnt_rst, upd_req, cen_set;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    slave_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .counter_en(counter_en), .mode_sel(mode_sel),
        .trig_sel(trig_sel), .int_trig(int_trig), .ch1_in(ch1_in), .ch2_in(ch2_in),
        .ext_trig(ext_trig), .cnt_en(cnt_en), .cnt_dir(cnt_dir), .cnt_rst(cnt_rst),
        .upd_req(upd_req), .cen_set(cen_set)
    );

    localparam logic [2:0] K_IDLE = 3'd0, K_PULSE = 3'd1, K_OTHER = 3'd2,
                           K_FWD = 3'd3, K_REV = 3'd4, K_BOTH = 3'd5;
    localparam int WIN = 40;

    typedef struct packed {
        logic [3:0] mode;
        logic [2:0] tsel;
        logic       cen;
        logic [2:0] kind;
        logic [7:0] en;
        logic [3:0] rst;
        logic [3:0] set;
        logic       dir;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 3'd0, 1'b1, K_IDLE,  8'd40, 4'd0, 4'd0, 1'b0, 4'd2},  // R2 pass-through
        '{4'h0, 3'd5, 1'b0, K_PULSE, 8'd0,  4'd0, 4'd0, 1'b0, 4'd2},  // R2 trigger ignored
        '{4'hA, 3'd5, 1'b1, K_PULSE, 8'd40, 4'd0, 4'd0, 1'b0, 4'd2},  // R2 undefined code
        '{4'h4, 3'd7, 1'b1, K_PULSE, 8'd40, 4'd1, 4'd0, 1'b0, 4'd5},  // R5 reset mode
        '{4'h4, 3'd1, 1'b0, K_PULSE, 8'd0,  4'd1, 4'd0, 1'b0, 4'd13}, // R13 reset without enable
        '{4'h5, 3'd5, 1'b1, K_PULSE, 8'd6,  4'd0, 4'd0, 1'b0, 4'd6},  // R6 gate width 6
        '{4'h5, 3'd5, 1'b0, K_PULSE, 8'd0,  4'd0, 4'd0, 1'b0, 4'd13}, // R13 gate blocked
        '{4'h6, 3'd2, 1'b0, K_PULSE, 8'd0,  4'd0, 4'd1, 1'b0, 4'd7},  // R7 start strobe
        '{4'h7, 3'd6, 1'b1, K_PULSE, 8'd1,  4'd0, 4'd0, 1'b0, 4'd8},  // R8 external clock
        '{4'h7, 3'd6, 1'b1, K_OTHER, 8'd0,  4'd0, 4'd0, 1'b0, 4'd4},  // R4 unselected inputs
        '{4'h7, 3'd4, 1'b1, K_PULSE, 8'd2,  4'd0, 4'd0, 1'b0, 4'd4},  // R4 either edge of ch1
        '{4'h7, 3'd3, 1'b1, K_PULSE, 8'd1,  4'd0, 4'd0, 1'b0, 4'd4},  // R4 internal trigger 3
        '{4'h8, 3'd0, 1'b1, K_PULSE, 8'd40, 4'd1, 4'd1, 1'b0, 4'd9},  // R9 reset and start
        '{4'h3, 3'd0, 1'b1, K_FWD,   8'd4,  4'd0, 4'd0, 1'b0, 4'd10}, // R10 both channels
        '{4'h3, 3'd0, 1'b1, K_REV,   8'd4,  4'd0, 4'd0, 1'b1, 4'd11}, // R11 reverse -> down
        '{4'h1, 3'd0, 1'b1, K_FWD,   8'd2,  4'd0, 4'd0, 1'b0, 4'd11}, // R11 forward -> up, ch2 only
        '{4'h2, 3'd0, 1'b1, K_REV,   8'd2,  4'd0, 4'd0, 1'b1, 4'd10}, // R10 ch1 only
        '{4'h3, 3'd0, 1'b1, K_BOTH,  8'd0,  4'd0, 4'd0, 1'b1, 4'd12}, // R12 simultaneous, dir held
        '{4'h1, 3'd0, 1'b0, K_FWD,   8'd0,  4'd0, 4'd0, 1'b0, 4'd13}  // R13 no count, dir tracked
    };

    // Bit layout: [3:0] internal triggers, [4] ch1, [5] ch2, [6] external.
    function automatic logic [6:0] stim(input logic [2:0] kind, input logic [2:0] tsel, input int i);
        logic [6:0] m;
        logic       pulse;
        int         pos;
        if (tsel < 3'd4)                     m = 7'(1 << tsel);
        else if (tsel == 3'd4 || tsel == 3'd5) m = 7'b0010000;
        else if (tsel == 3'd6)               m = 7'b0100000;
        else                                 m = 7'b1000000;
        pulse = (i >= 2 && i < 8);
        pos = (i < 2) ? 0 : (((i - 2) / 5 + 1) > 4 ? 4 : ((i - 2) / 5 + 1));
        case (kind)
            K_PULSE: return pulse ? m : 7'd0;
            K_OTHER: return pulse ? ~m : 7'd0;
            K_FWD:   case (pos)
                         1: return 7'b0010000;
                         2: return 7'b0110000;
                         3: return 7'b0100000;
                         default: return 7'd0;
                     endcase
            K_REV:   case (pos)
                         1: return 7'b0100000;
                         2: return 7'b0110000;
                         3: return 7'b0010000;
                         default: return 7'd0;
                     endcase
            K_BOTH:  return (i >= 2 && i < 7) ? 7'b0110000 : 7'd0;
            default: return 7'd0;
        endcase
    endfunction

    task automatic apply(input logic [6:0] v);
        int_trig = v[3:0];
        ch1_in   = v[4];
        ch2_in   = v[5];
        ext_trig = v[6];
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int n_en, n_rst, n_upd, n_set;
        string rq;
        apply(7'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs held at 0 during reset
        chk({cnt_en, cnt_dir, cnt_rst, upd_req, cen_set} == 5'd0, "R1", "outputs in reset",
            {cnt_en, cnt_dir, cnt_rst, upd_req, cen_set}, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            mode_sel   = VECS[v].mode;
            trig_sel   = VECS[v].tsel;
            counter_en = VECS[v].cen;
            apply(7'd0);
            repeat (6) @(negedge clk);
            n_en = 0; n_rst = 0; n_upd = 0; n_set = 0;
            for (int i = 0; i < WIN; i++) begin
                if (i > 0) @(negedge clk);
                n_en  += int'(cnt_en);
                n_rst += int'(cnt_rst);
                n_upd += int'(upd_req);
                n_set += int'(cen_set);
                apply(stim(VECS[v].kind, VECS[v].tsel, i));
            end
            rq = $sformatf("R%0d vec%0d", VECS[v].req, v);
            chk(n_en == int'(VECS[v].en), rq, "cnt_en count", n_en, int'(VECS[v].en));
            chk(n_rst == int'(VECS[v].rst), rq, "cnt_rst count", n_rst, int'(VECS[v].rst));
            chk(n_upd == int'(VECS[v].rst), rq, "upd_req count", n_upd, int'(VECS[v].rst));
            chk(n_set == int'(VECS[v].set), rq, "cen_set count", n_set, int'(VECS[v].set));
            chk(cnt_dir == VECS[v].dir, rq, "cnt_dir", int'(cnt_dir), int'(VECS[v].dir));
        end

        // R3: reset strobe appears after the third edge, lasts one cycle
        @(negedge clk);
        mode_sel = 4'h4; trig_sel = 3'd7; counter_en = 1'b0;
        repeat (4) @(negedge clk);
        ext_trig = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk(cnt_rst == 1'b0, "R3", "after 2nd edge", int'(cnt_rst), 0);
        @(posedge clk); #1;
        chk(cnt_rst == 1'b1, "R3", "after 3rd edge", int'(cnt_rst), 1);
        @(posedge clk); #1;
        chk(cnt_rst == 1'b0, "R3", "after 4th edge", int'(cnt_rst), 0);
        @(negedge clk);
        ext_trig = 1'b0;

        // R1: reset in the middle of activity clears the outputs
        mode_sel = 4'h0; counter_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(cnt_en == 1'b1, "R2", "enable before reset", int'(cnt_en), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk({cnt_en, cnt_dir, cnt_rst, upd_req, cen_set} == 5'd0, "R1", "outputs after mid-run reset",
            {cnt_en, cnt_dir, cnt_rst, upd_req, cen_set}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule